// File: doc/BRIEF.md
# Up/Up-Down Timer with Event Decimation

This block is a 16-bit timer counter with two counting shapes. In sawtooth shape it counts up to a programmed period and then wraps to zero. In triangle shape it climbs to the period, falls back to zero, and repeats. Each direction change happens on the very next count tick, with no extra tick spent at either end. Reaching the period produces a peak event and reaching zero produces a zero event.

Each event has its own decimator. The decimator sets a sticky flag on one occurrence in every M+1, where M is a programmable 4-bit skip count. Each flag drives an interrupt line that has its own enable. The count tick comes from one of two sources:
- the bus clock, divided by a power of two that the user selects;
- an external pin, synchronized by two flops and reduced to one tick per rising edge.

Software drives the block through single-cycle strobes. The strobes start and stop the counter, clear it, load it, write the period, write the skip counts and clear the flags. A period write can either take effect at once or wait in a shadow register until the next zero event. The block has no data stream, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0, the active period is 0xFFFF, the status word and both interrupt lines are 0, and the counter is stopped.
- R2: With `shape_sel`=0 (sawtooth), each tick moves the count from c to c+1 while c is below the period. At or above the period, a tick moves the count to 0. A peak event occurs when the count becomes equal to the period, and a zero event occurs when it becomes 0.
- R3: With `shape_sel`=1 (triangle), the count rises to the period and then falls to 0. A tick reverses the direction at each end, so the period and 0 are each held for one tick only. A peak event occurs on reaching the period and a zero event on reaching 0.
- R4: With `src_sel`=0, a pre-select code k from 0 to 10 gives one tick per 2^k running clock cycles. The first tick comes 2^k cycles after the start. Codes 11 to 15 act as code 10.
- R5: With `src_sel`=1, each rising edge on `ext_clk_pin` gives exactly one tick after a two-flop synchronizer. A pin held high gives no further ticks.
- R6: `start_req` sets the counter running and `stop_req` stops it; if both are raised together, stop wins. While the counter is stopped, the count changes only through clear or load.
- R7: `clear_req` sets the count to 0 and `load_req` sets it to `load_val`. Either one also sets the direction to up. Clear wins over load, and load wins over a tick.
- R8: With `buf_en`=0, a period write reaches `period_act` on the next cycle. With `buf_en`=1, the write goes to a shadow register and is copied to `period_act` on the next zero event.
- R9: With skip count M, the event flag is set on the (M+1)th event and on every (M+1)th event after it. M=0 sets the flag on every event.
- R10: Writing a skip count restarts that event's decimation, so the flag is set again only after M+1 further events.
- R11: The zero flag is `status` bit 8 and the peak flag is `status` bit 13. All other status bits read 0. A flag stays set until its clear strobe. If a set and a clear land in the same cycle, the set wins.
- R12: `zero_irq` equals the zero flag gated by `zero_en`, and `peak_irq` equals the peak flag gated by `peak_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| shape_sel | input | 1 | 0 sawtooth, 1 triangle |
| src_sel | input | 1 | 0 divided bus clock, 1 external pin |
| pre_sel | input | 4 | Prescaler code k, divide by 2^k |
| buf_en | input | 1 | Buffer period writes until a zero event |
| zero_en | input | 1 | Zero interrupt enable |
| peak_en | input | 1 | Peak interrupt enable |
| start_req | input | 1 | Start strobe |
| stop_req | input | 1 | Stop strobe |
| clear_req | input | 1 | Clear-count strobe |
| load_req | input | 1 | Load-count strobe |
| load_val | input | 16 | Value for load |
| period_wr | input | 1 | Period write strobe |
| period_val | input | 16 | Period write data |
| zero_skip_wr | input | 1 | Zero skip-count write strobe |
| zero_skip_val | input | 4 | Zero skip count M |
| peak_skip_wr | input | 1 | Peak skip-count write strobe |
| peak_skip_val | input | 4 | Peak skip count M |
| zero_clr | input | 1 | Zero flag clear strobe |
| peak_clr | input | 1 | Peak flag clear strobe |
| count | output | 16 | Current count |
| period_act | output | 16 | Active period |
| running | output | 1 | Counter is running |
| status | output | 16 | Flag word (bit 8 zero, bit 13 peak) |
| zero_irq | output | 1 | Zero interrupt |
| peak_irq | output | 1 | Peak interrupt |

## Verification
The bench targets the points where the turn-around logic of each shape is easy to get wrong:
- **Triangle turn-around.** A design that held the top or bottom value for an extra tick would land off by one or two in the long triangle runs.
- **Skip count.** Setting the flag on the Mth event rather than the (M+1)th would show up in the skip tests. So would keeping the old decimation position after a fresh skip write, because the flag would then appear two events early.
- **Buffered period.** A buffered period that reached the counter before the zero event would make the count wrap early.
- **Load direction.** A load that kept the falling direction would count down instead of up.
- **Prescaler and external pin.** The tick-count vectors catch a prescaler that is off by one power of two. Holding the external pin high catches a level-counting input, which would run away instead of counting once.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam int STAT_W        = 16;
  localparam int STAT_ZERO_BIT = 8;
  localparam int STAT_PEAK_BIT = 13;
  localparam int N_EVT         = 2;
  localparam int EVT_ZERO      = 0;
  localparam int EVT_PEAK      = 1;

  typedef enum logic {
    SHAPE_SAW = 1'b0,
    SHAPE_TRI = 1'b1
  } shape_e;

  typedef enum logic {
    SRC_BUS = 1'b0,
    SRC_PIN = 1'b1
  } src_e;
endpackage

// File: rtl/updn_tick_gen.sv
module updn_tick_gen #(
  parameter int PRE_SEL_W   = 4,
  parameter int PRE_MAX     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 src_pin,
  input  logic [PRE_SEL_W-1:0] pre_sel,
  input  logic                 ext_pin,
  output logic                 tick
);
  localparam int DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1;
  localparam logic [PRE_SEL_W-1:0] PRE_CAP = PRE_SEL_W'(PRE_MAX);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [PRE_SEL_W-1:0] code_eff;
  logic [DIV_W-1:0]     div_mask;
  logic [DIV_W-1:0]     div_q;
  logic                 bus_tick;
  logic [SYNC_STAGES:0] sync_q;
  logic                 pin_tick;

  // codes beyond the largest divider saturate
  always_comb begin
    code_eff = (pre_sel > PRE_CAP) ? PRE_CAP : pre_sel;
    div_mask = DIV_W'((32'd1 << code_eff) - 32'd1);
  end

  // free-running divider, parked at zero while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + DIV_ONE;
  end

  assign bus_tick = ((div_q & div_mask) == div_mask);

  // synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_pin};
  end

  assign pin_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick     = run & (src_pin ? pin_tick : bus_tick);
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             shape,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_val,
  input  logic             buf_en,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] per_act,
  output logic             zero_evt,
  output logic             peak_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt_cnt, per_q, shadow_q;
  logic             down_q, nxt_down;
  logic             step, zero_fire, peak_fire;

  // next count for one tick
  always_comb begin
    nxt_cnt  = cnt_q;
    nxt_down = down_q;
    if (shape == SHAPE_SAW) begin
      nxt_down = 1'b0;
      nxt_cnt  = (cnt_q >= per_q) ? '0 : cnt_q + ONE;
    end else if (per_q == '0) begin
      nxt_down = 1'b0;
      nxt_cnt  = '0;
    end else if (!down_q) begin
      if (cnt_q >= per_q) begin
        nxt_cnt  = cnt_q - ONE;
        nxt_down = 1'b1;
      end else begin
        nxt_cnt  = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        nxt_cnt  = ONE;
        nxt_down = 1'b0;
      end else begin
        nxt_cnt  = cnt_q - ONE;
      end
    end
  end

  assign step      = tick & ~clr & ~load;
  assign zero_fire = step & (nxt_cnt == '0);
  assign peak_fire = step & (nxt_cnt == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= nxt_cnt;
      down_q <= nxt_down;
    end
  end

  // period: shadow always tracks the latest write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      per_q    <= '1;
    end else begin
      if (per_wr) shadow_q <= per_val;
      if (per_wr && !buf_en)        per_q <= per_val;
      else if (buf_en && zero_fire) per_q <= shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_evt <= 1'b0;
      peak_evt <= 1'b0;
    end else begin
      zero_evt <= zero_fire;
      peak_evt <= peak_fire;
    end
  end

  assign count   = cnt_q;
  assign per_act = per_q;
endmodule

// File: rtl/updn_evt_decim.sv
module updn_evt_decim #(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              skip_wr,
  input  logic [SKIP_W-1:0] skip_val,
  input  logic              flag_clr,
  output logic              flag
);
  localparam logic [SKIP_W-1:0] ONE = SKIP_W'(1);

  logic [SKIP_W-1:0] limit_q, seen_q;
  logic              fire, flag_q;

  assign fire = evt & ~skip_wr & (seen_q >= limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      seen_q  <= '0;
    end else if (skip_wr) begin
      limit_q <= skip_val;
      seen_q  <= '0;
    end else if (evt) begin
      seen_q <= (seen_q >= limit_q) ? '0 : seen_q + ONE;
    end
  end

  // sticky flag, a new set beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= fire | (flag_q & ~flag_clr);
  end

  assign flag = flag_q;
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SKIP_W      = 4,
  parameter int PRE_SEL_W   = 4,
  parameter int PRE_MAX     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_clk_pin,
  input  logic                 shape_sel,
  input  logic                 src_sel,
  input  logic [PRE_SEL_W-1:0] pre_sel,
  input  logic                 buf_en,
  input  logic                 zero_en,
  input  logic                 peak_en,
  input  logic                 start_req,
  input  logic                 stop_req,
  input  logic                 clear_req,
  input  logic                 load_req,
  input  logic [CNT_W-1:0]     load_val,
  input  logic                 period_wr,
  input  logic [CNT_W-1:0]     period_val,
  input  logic                 zero_skip_wr,
  input  logic [SKIP_W-1:0]    zero_skip_val,
  input  logic                 peak_skip_wr,
  input  logic [SKIP_W-1:0]    peak_skip_val,
  input  logic                 zero_clr,
  input  logic                 peak_clr,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     period_act,
  output logic                 running,
  output logic [STAT_W-1:0]    status,
  output logic                 zero_irq,
  output logic                 peak_irq
);
  logic run_q, tick, zero_evt, peak_evt;
  logic [N_EVT-1:0]  evt_v, skip_wr_v, clr_v, flag_v, en_v;
  logic [SKIP_W-1:0] skip_val_v [N_EVT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= 1'b0;
    else if (stop_req)  run_q <= 1'b0;
    else if (start_req) run_q <= 1'b1;
  end

  updn_tick_gen #(
    .PRE_SEL_W(PRE_SEL_W), .PRE_MAX(PRE_MAX), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_q), .src_pin(src_sel == SRC_PIN),
    .pre_sel(pre_sel), .ext_pin(ext_clk_pin), .tick(tick)
  );

  updn_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shape(shape_sel),
    .clr(clear_req), .load(load_req), .load_val(load_val),
    .per_wr(period_wr), .per_val(period_val), .buf_en(buf_en),
    .count(count), .per_act(period_act),
    .zero_evt(zero_evt), .peak_evt(peak_evt)
  );

  always_comb begin
    evt_v[EVT_ZERO]      = zero_evt;
    evt_v[EVT_PEAK]      = peak_evt;
    skip_wr_v[EVT_ZERO]  = zero_skip_wr;
    skip_wr_v[EVT_PEAK]  = peak_skip_wr;
    skip_val_v[EVT_ZERO] = zero_skip_val;
    skip_val_v[EVT_PEAK] = peak_skip_val;
    clr_v[EVT_ZERO]      = zero_clr;
    clr_v[EVT_PEAK]      = peak_clr;
    en_v[EVT_ZERO]       = zero_en;
    en_v[EVT_PEAK]       = peak_en;
  end

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_evt
    updn_evt_decim #(.SKIP_W(SKIP_W)) u_decim (
      .clk(clk), .rst_n(rst_n), .evt(evt_v[gi]), .skip_wr(skip_wr_v[gi]),
      .skip_val(skip_val_v[gi]), .flag_clr(clr_v[gi]), .flag(flag_v[gi])
    );
  end

  always_comb begin
    status                = '0;
    status[STAT_ZERO_BIT] = flag_v[EVT_ZERO];
    status[STAT_PEAK_BIT] = flag_v[EVT_PEAK];
  end

  assign running  = run_q;
  assign zero_irq = flag_v[EVT_ZERO] & en_v[EVT_ZERO];
  assign peak_irq = flag_v[EVT_PEAK] & en_v[EVT_PEAK];
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_req,
  input logic             load_req,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [15:0]      status,
  input logic             zero_clr,
  input logic             peak_clr,
  input logic             zero_en,
  input logic             peak_en,
  input logic             zero_irq,
  input logic             peak_irq
);
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (count == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clear_req && !load_req) |=> $stable(count));
  // R11
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[8] && !zero_clr) |=> status[8]);
  // R11
  peak_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[13] && !peak_clr) |=> status[13]);
  // R11
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~16'h2100) == 16'h0000);
  // R12
  zero_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_en |-> !zero_irq);
  // R12
  peak_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_en |-> !peak_irq);
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .load_req(load_req),
  .running(running), .count(count), .status(status),
  .zero_clr(zero_clr), .peak_clr(peak_clr), .zero_en(zero_en),
  .peak_en(peak_en), .zero_irq(zero_irq), .peak_irq(peak_irq)
);

// File: tb/test_updn_timer.sv
`timescale 1ns/1ps
module test_updn_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk_pin = 0, shape_sel = 0, src_sel = 0, buf_en = 0;
  logic zero_en = 1, peak_en = 1;
  logic [3:0] pre_sel = 0;
  logic start_req = 0, stop_req = 0, clear_req = 0, load_req = 0;
  logic [15:0] load_val = 0, period_val = 0;
  logic period_wr = 0, zero_skip_wr = 0, peak_skip_wr = 0;
  logic [3:0] zero_skip_val = 0, peak_skip_val = 0;
  logic zero_clr = 0, peak_clr = 0;
  logic [15:0] count, period_act, status;
  logic running, zero_irq, peak_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updn_timer i_updn_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin), .shape_sel(shape_sel),
    .src_sel(src_sel), .pre_sel(pre_sel), .buf_en(buf_en), .zero_en(zero_en),
    .peak_en(peak_en), .start_req(start_req), .stop_req(stop_req),
    .clear_req(clear_req), .load_req(load_req), .load_val(load_val),
    .period_wr(period_wr), .period_val(period_val),
    .zero_skip_wr(zero_skip_wr), .zero_skip_val(zero_skip_val),
    .peak_skip_wr(peak_skip_wr), .peak_skip_val(peak_skip_val),
    .zero_clr(zero_clr), .peak_clr(peak_clr), .count(count),
    .period_act(period_act), .running(running), .status(status),
    .zero_irq(zero_irq), .peak_irq(peak_irq)
  );

  typedef struct packed {
    logic        shape;
    logic [3:0]  pre;
    logic [15:0] per;
    logic [15:0] ncyc;
    logic [15:0] exp_cnt;
    logic        exp_z;
    logic        exp_p;
  } vec_t;

  // ticks T = ncyc >> pre; saw count T mod (P+1); tri folds T mod 2P
  localparam vec_t VECS [10] = '{
    '{1'b0, 4'd0,  16'd9,   16'd5,    16'd5,  1'b0, 1'b0},
    '{1'b0, 4'd0,  16'd9,   16'd10,   16'd0,  1'b1, 1'b1},
    '{1'b0, 4'd0,  16'd9,   16'd23,   16'd3,  1'b1, 1'b1},
    '{1'b1, 4'd0,  16'd9,   16'd12,   16'd6,  1'b0, 1'b1},
    '{1'b1, 4'd0,  16'd9,   16'd25,   16'd7,  1'b1, 1'b1},
    '{1'b0, 4'd2,  16'd100, 16'd40,   16'd10, 1'b0, 1'b0},
    '{1'b1, 4'd1,  16'd4,   16'd22,   16'd3,  1'b1, 1'b1},
    '{1'b0, 4'd3,  16'd3,   16'd45,   16'd1,  1'b1, 1'b1},
    '{1'b1, 4'd10, 16'd5,   16'd3000, 16'd2,  1'b0, 1'b0},
    '{1'b0, 4'd12, 16'd5,   16'd2100, 16'd2,  1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start, n running edges (each may tick), stop, settle
  task automatic run_for(input int n);
    start_req = 1; cyc(1); start_req = 0;
    cyc(n - 1);
    stop_req = 1; cyc(1); stop_req = 0;
    cyc(3);
  endtask

  task automatic set_period(input logic [15:0] p);
    period_val = p; period_wr = 1; cyc(1); period_wr = 0;
  endtask

  task automatic do_clear();
    clear_req = 1; cyc(1); clear_req = 0;
  endtask

  task automatic clr_flags();
    zero_clr = 1; peak_clr = 1; cyc(1); zero_clr = 0; peak_clr = 0;
  endtask

  task automatic set_skips(input logic [3:0] mz, input logic [3:0] mp);
    zero_skip_val = mz; peak_skip_val = mp;
    zero_skip_wr = 1; peak_skip_wr = 1; cyc(1);
    zero_skip_wr = 0; peak_skip_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 period", period_act, 16'hFFFF);
    check("R1 status", status, 0);
    check("R1 running", running, 0);
    check("R1 irq", {zero_irq, peak_irq}, 0);
    rst_n = 1;
    cyc(2);

    // table walk: R2 sawtooth, R3 triangle, R4 prescaler
    foreach (VECS[i]) begin
      shape_sel = VECS[i].shape;
      pre_sel   = VECS[i].pre;
      set_period(VECS[i].per);
      do_clear();
      clr_flags();
      run_for(int'(VECS[i].ncyc));
      check($sformatf("R2/R3/R4 vec%0d count", i), count, VECS[i].exp_cnt);
      check($sformatf("R2/R3 vec%0d zero flag", i), status[8], VECS[i].exp_z);
      check($sformatf("R2/R3 vec%0d peak flag", i), status[13], VECS[i].exp_p);
    end

    // R9 skip count: saw P=1, zero events every 2 ticks, M=2
    shape_sel = 0; pre_sel = 0;
    set_period(1); do_clear(); set_skips(2, 0); clr_flags();
    run_for(5);
    check("R9 count after 5", count, 1);
    check("R9 zero flag after 2 events", status[8], 0);
    check("R9 peak flag M=0", status[13], 1);
    run_for(1);
    check("R9 zero flag on 3rd event", status[8], 1);
    check("R12 zero irq enabled", zero_irq, 1);
    zero_en = 0; cyc(1);
    check("R12 zero irq gated", zero_irq, 0);
    zero_en = 1;
    zero_clr = 1; cyc(1); zero_clr = 0;
    check("R11 zero flag cleared", status[8], 0);
    check("R11 peak flag kept", status[13], 1);
    run_for(4);
    check("R9 two events after fire", status[8], 0);
    run_for(1);
    // R10: rewrite restarts decimation (two events already seen)
    set_skips(2, 0);
    run_for(4);
    check("R10 no fire after 2 events", status[8], 0);
    run_for(2);
    check("R10 fire on 3rd event", status[8], 1);

    // R8 buffered period
    set_skips(0, 0);
    buf_en = 0; set_period(9); do_clear();
    buf_en = 1; set_period(3); cyc(1);
    check("R8 buffered hold", period_act, 9);
    run_for(5);
    check("R8 count with old period", count, 5);
    run_for(5);
    check("R8 count at wrap", count, 0);
    check("R8 transfer at zero", period_act, 3);
    run_for(6);
    check("R8 count with new period", count, 2);
    buf_en = 0; set_period(20);
    check("R8 unbuffered at once", period_act, 20);

    // R7 load / clear, R6 hold while stopped
    load_val = 16'h1234; load_req = 1; cyc(1); load_req = 0;
    check("R7 load", count, 16'h1234);
    cyc(20);
    check("R6 stopped hold", count, 16'h1234);
    load_val = 16'h0055; load_req = 1; clear_req = 1; cyc(1);
    load_req = 0; clear_req = 0;
    check("R7 clear beats load", count, 0);
    // R7 load sets direction up: tri P=9, 12 ticks -> 6 falling
    shape_sel = 1; set_period(9); do_clear();
    run_for(12);
    load_val = 5; load_req = 1; cyc(1); load_req = 0;
    run_for(1);
    check("R7 load direction up", count, 6);
    // R6 stop wins over start
    start_req = 1; stop_req = 1; cyc(1); start_req = 0; stop_req = 0;
    check("R6 stop wins", running, 0);

    // R5 external pin
    shape_sel = 0; src_sel = 1; set_period(100); do_clear();
    start_req = 1; cyc(1); start_req = 0;
    for (int k = 0; k < 5; k++) begin
      ext_clk_pin = 1; cyc(4);
      ext_clk_pin = 0; cyc(4);
    end
    cyc(6);
    check("R5 five edges", count, 5);
    ext_clk_pin = 1; cyc(20);
    check("R5 level held", count, 6);
    stop_req = 1; cyc(1); stop_req = 0; ext_clk_pin = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule